// File: doc/BRIEF.md
# Pipelined Locked Bus Cycle Issuer

This block takes bus cycle requests from an internal queue and starts them on a processor local bus. Each request carries an address, a memory or I/O type, a single-beat or four-beat transfer length, and a locked flag. A locked request also carries a flag that marks it as the last cycle of its atomic sequence. The block drives an active-low address strobe, a type line and a bus address. It counts active-low ready beats from the bus so it knows when each cycle ends.

An active-low early-address input lets the external memory system accept a new cycle before the data of the current one has finished. Sampled low, it causes the strobe for the next queued cycle two clocks later. This keeps up to two cycles in flight. A locked sequence holds the active-low bus lock line low from the strobe of its first cycle until its closing cycle has received its final beat. Other traffic is held back until that sequence is complete, and the lock line is released for at least one clock before a new sequence may start.

Top module: `lockseq_issuer`

## Requirements
- R1: While reset is low, and in the first clock after it is released, `strobeN` and `busLockN` are high and `reqTaken` is low when no request is presented.
- R2: In every clock in which `strobeN` is low, `busIsMem` (1 = memory, 0 = I/O) and `busAddr` equal the type and address of the request that was taken at the edge that started that strobe.
- R3: With no cycle outstanding and an issuable request presented, `reqTaken` is high in that clock, and `strobeN` is low for exactly the one following clock.
- R4: If `earlyAddrN` is sampled low while exactly one cycle is outstanding and an issuable request is presented, that request's strobe appears two clocks after the clock in which `earlyAddrN` was low.
- R5: No more than two cycles are ever outstanding, and no strobe is started while two are outstanding.
- R6: A cycle completes on the edge that samples its last low `readyN` beat, which is beat 1 when `reqFourBeat` was 0 and beat 4 when it was 1. `readyN` is ignored when nothing is outstanding. It is also ignored in the strobe clock of a cycle that is the only one outstanding.
- R7: `busLockN` goes low in the same clock as the strobe of the first cycle of a locked sequence, and stays low across the sequence.
- R8: `busLockN` goes high in the clock after the edge that samples the final ready beat of the cycle whose request had `reqLocked` = 1 and `reqSeqEnd` = 1.
- R9: Between two back-to-back locked sequences, `busLockN` is high for at least one clock, and no strobe occurs in the first clock after the lock is released.
- R10: `earlyAddrN` is ignored and not remembered when two cycles are outstanding or when no issuable request is presented.
- R11: While a locked sequence is open, an unlocked request is not taken. Once the sequence's closing cycle has been taken, a locked request for a new sequence is not taken until the closing cycle completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Queue head holds a request |
| reqIsMem | input | 1 | Request type, 1 = memory, 0 = I/O |
| reqLocked | input | 1 | Request belongs to a locked sequence |
| reqSeqEnd | input | 1 | Locked request closes its sequence |
| reqFourBeat | input | 1 | 1 = four ready beats, 0 = one beat |
| reqAddr | input | ADDR_W | Request address |
| reqTaken | output | 1 | Request is taken at this clock edge |
| strobeN | output | 1 | Active-low address strobe |
| busIsMem | output | 1 | Cycle type line, valid with the strobe |
| busAddr | output | ADDR_W | Cycle address, valid with the strobe |
| busLockN | output | 1 | Active-low bus lock |
| earlyAddrN | input | 1 | Active-low early next-address input |
| readyN | input | 1 | Active-low transfer ready |

## Verification
A wrong outstanding count shows within two clocks. It either produces a strobe where none is allowed, or it blocks one that the early-address pulse or an idle bus should have produced. A miscounted beat moves the next idle strobe earlier or later by whole clocks, so the bench measures it by the exact clock of that strobe. A lock flag that is stale or cleared too early shows on `busLockN` in the clock after the closing beat, or as an unlocked strobe inside a sequence. The scenarios therefore check strobe absence and presence in every clock around each event.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic issue;   // take queue head, start a bus cycle
    logic retire;  // oldest outstanding cycle has completed
  } ctlStrobes_t;

  // Per-outstanding-cycle tag kept by the datapath
  typedef struct packed {
    logic fourBeat;   // cycle expects the long beat count
    logic closesSeq;  // cycle is the last one of a locked sequence
  } slotTag_t;

endpackage

// File: rtl/lockseq_ctrl.sv
module lockseq_ctrl
  import lockseq_pkg::*;
#(
  parameter int MAX_OUT    = 2,
  parameter int LONG_BEATS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqLocked,
  input  logic        reqSeqEnd,
  input  logic        earlyAddrN,
  input  logic        readyN,
  input  slotTag_t    headTag,
  output ctlStrobes_t strb,
  output logic        strobeN,
  output logic        busLockN
);

  localparam int CNT_W  = $clog2(MAX_OUT + 1);
  localparam int BEAT_W = (LONG_BEATS > 1) ? $clog2(LONG_BEATS) : 1;
  localparam logic [CNT_W-1:0]  FULL     = CNT_W'(MAX_OUT);
  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(LONG_BEATS - 1);

  logic [CNT_W-1:0]  outCnt;
  logic [BEAT_W-1:0] beatCnt;
  logic              naPend;
  logic              lockOpen;
  logic              endIssued;
  logic              strobeQ;

  logic reqOk, issue, naAccept, readyOk, lastBeat, retire, closeNow;

  always_comb begin
    // issuable: lock rules decide which heads may start
    if (reqLocked) reqOk = reqValid && !(lockOpen && endIssued);
    else           reqOk = reqValid && !lockOpen;

    issue    = reqOk && (outCnt < FULL) && ((outCnt == '0) || naPend);
    naAccept = !earlyAddrN && reqOk && !naPend &&
               (outCnt != '0) && (outCnt < FULL);

    readyOk  = !readyN && (outCnt != '0) &&
               !(strobeQ && (outCnt == CNT_W'(1)));
    lastBeat = headTag.fourBeat ? (beatCnt == LAST_IDX) : 1'b1;
    retire   = readyOk && lastBeat;
    closeNow = retire && headTag.closesSeq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCnt    <= '0;
      beatCnt   <= '0;
      naPend    <= 1'b0;
      lockOpen  <= 1'b0;
      endIssued <= 1'b0;
      strobeQ   <= 1'b0;
    end else begin
      outCnt  <= outCnt + CNT_W'(issue) - CNT_W'(retire);
      strobeQ <= issue;

      if (retire)       beatCnt <= '0;
      else if (readyOk) beatCnt <= beatCnt + BEAT_W'(1);

      if (issue)         naPend <= 1'b0;
      else if (naAccept) naPend <= 1'b1;
      else               naPend <= naPend && reqOk;

      lockOpen  <= (lockOpen | (issue && reqLocked)) & ~closeNow;
      endIssued <= (endIssued | (issue && reqLocked && reqSeqEnd)) & ~closeNow;
    end
  end

  assign strb.issue  = issue;
  assign strb.retire = retire;
  assign strobeN     = ~strobeQ;
  assign busLockN    = ~lockOpen;

  // R5: outstanding count never exceeds the limit
  p_out_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= FULL);

  // R3: an idle bus with an issuable head strobes at the next edge
  p_idle_issue_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outCnt == '0 && reqOk) |=> strobeQ);

  // R4: accepted early-address pulse yields a strobe two clocks later
  p_na_two_clk_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!earlyAddrN && reqOk && outCnt == CNT_W'(1) && !naPend) ##1 reqOk
      |=> strobeQ);

  // R7: lock opens together with a strobe
  p_lock_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOpen) |-> strobeQ);

  // R8: lock only closes after a completing beat
  p_lock_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockOpen) |-> $past(retire));

  // R9: no strobe in the first clock after lock release
  p_lock_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockOpen) |-> !strobeQ);

  // R11: unlocked heads are held while a sequence is open
  p_unlocked_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (lockOpen && !reqLocked) |-> !issue);

endmodule

// File: rtl/lockseq_dpath.sv
module lockseq_dpath
  import lockseq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_OUT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              reqIsMem,
  input  logic              reqLocked,
  input  logic              reqSeqEnd,
  input  logic              reqFourBeat,
  input  logic [ADDR_W-1:0] reqAddr,
  output slotTag_t          headTag,
  output logic              busIsMem,
  output logic [ADDR_W-1:0] busAddr
);

  localparam int PTR_W = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MAX_OUT - 1);

  slotTag_t          tags [MAX_OUT];
  slotTag_t          newTag;
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  assign newTag.fourBeat  = reqFourBeat;
  assign newTag.closesSeq = reqLocked & reqSeqEnd;

  // Bus-facing cycle definition registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busIsMem <= 1'b0;
      busAddr  <= '0;
    end else if (strb.issue) begin
      busIsMem <= reqIsMem;
      busAddr  <= reqAddr;
    end
  end

  // Ring pointers for the outstanding-cycle tags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.issue)  wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + PTR_W'(1);
      if (strb.retire) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + PTR_W'(1);
    end
  end

  for (genvar g = 0; g < MAX_OUT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)                                  tags[g] <= '0;
      else if (strb.issue && wrPtr == PTR_W'(g))  tags[g] <= newTag;
    end
  end

  assign headTag = tags[rdPtr];

endmodule

// File: rtl/lockseq_issuer.sv
module lockseq_issuer
  import lockseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_OUT    = 2,
  parameter int LONG_BEATS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsMem,
  input  logic              reqLocked,
  input  logic              reqSeqEnd,
  input  logic              reqFourBeat,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqTaken,
  output logic              strobeN,
  output logic              busIsMem,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busLockN,
  input  logic              earlyAddrN,
  input  logic              readyN
);

  ctlStrobes_t strb;
  slotTag_t    headTag;

  lockseq_ctrl #(
    .MAX_OUT    (MAX_OUT),
    .LONG_BEATS (LONG_BEATS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLocked  (reqLocked),
    .reqSeqEnd  (reqSeqEnd),
    .earlyAddrN (earlyAddrN),
    .readyN     (readyN),
    .headTag    (headTag),
    .strb       (strb),
    .strobeN    (strobeN),
    .busLockN   (busLockN)
  );

  lockseq_dpath #(
    .ADDR_W  (ADDR_W),
    .MAX_OUT (MAX_OUT)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqIsMem    (reqIsMem),
    .reqLocked   (reqLocked),
    .reqSeqEnd   (reqSeqEnd),
    .reqFourBeat (reqFourBeat),
    .reqAddr     (reqAddr),
    .headTag     (headTag),
    .busIsMem    (busIsMem),
    .busAddr     (busAddr)
  );

  assign reqTaken = strb.issue;

endmodule

// File: tb/lockseq_issuer_tb.sv
module lockseq_issuer_tb;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid, reqIsMem, reqLocked, reqSeqEnd, reqFourBeat;
  logic [AW-1:0] reqAddr;
  logic          reqTaken, strobeN, busIsMem, busLockN;
  logic [AW-1:0] busAddr;
  logic          earlyAddrN, readyN;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lockseq_issuer #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqIsMem(reqIsMem), .reqLocked(reqLocked),
    .reqSeqEnd(reqSeqEnd), .reqFourBeat(reqFourBeat), .reqAddr(reqAddr),
    .reqTaken(reqTaken), .strobeN(strobeN), .busIsMem(busIsMem),
    .busAddr(busAddr), .busLockN(busLockN),
    .earlyAddrN(earlyAddrN), .readyN(readyN)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic nx(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic present(logic mem, logic lck, logic send, logic four, logic [AW-1:0] a);
    reqValid = 1'b1; reqIsMem = mem; reqLocked = lck;
    reqSeqEnd = send; reqFourBeat = four; reqAddr = a;
  endtask

  task automatic quiet();
    reqValid = 1'b0; earlyAddrN = 1'b1; readyN = 1'b1;
  endtask

  task automatic t_reset();
    rstN = 1'b0; quiet();
    reqIsMem = 0; reqLocked = 0; reqSeqEnd = 0; reqFourBeat = 0; reqAddr = '0;
    nx(3);
    chk("R1", "strobe in reset", 32'(strobeN), 1);
    chk("R1", "lock in reset", 32'(busLockN), 1);
    chk("R1", "taken in reset", 32'(reqTaken), 0);
    rstN = 1'b1;
    nx();
    chk("R1", "strobe after reset", 32'(strobeN), 1);
    chk("R1", "lock after reset", 32'(busLockN), 1);
    nx();
  endtask

  // idle issue, type/address, ready ignored in sole strobe clock
  task automatic t_idle();
    present(1, 0, 0, 0, 32'h100);
    #1 chk("R3", "taken idle", 32'(reqTaken), 1);
    nx();
    chk("R3", "strobe A", 32'(strobeN), 0);
    chk("R2", "type A", 32'(busIsMem), 1);
    chk("R2", "addr A", busAddr, 32'h100);
    present(0, 0, 0, 0, 32'h200);
    readyN = 1'b0;
    nx();
    chk("R3", "strobe one clock", 32'(strobeN), 1);
    nx();
    chk("R6", "ready in strobe clock ignored", 32'(strobeN), 1);
    readyN = 1'b1;
    #1 chk("R3", "taken after retire", 32'(reqTaken), 1);
    nx();
    chk("R2", "strobe B", 32'(strobeN), 0);
    chk("R2", "type B io", 32'(busIsMem), 0);
    chk("R2", "addr B", busAddr, 32'h200);
    reqValid = 1'b0;
    nx(); readyN = 1'b0;
    nx(); readyN = 1'b1;
    nx(2);
  endtask

  // four-beat completion
  task automatic t_burst();
    present(1, 0, 0, 1, 32'h300);
    nx();
    chk("R6", "strobe burst", 32'(strobeN), 0);
    present(1, 0, 0, 0, 32'h340);
    nx(); readyN = 1'b0;
    nx();
    nx();
    chk("R6", "no strobe after 2 beats", 32'(strobeN), 1);
    nx();
    chk("R6", "no strobe after 3 beats", 32'(strobeN), 1);
    nx();
    chk("R6", "no strobe before 4th beat done", 32'(strobeN), 1);
    readyN = 1'b1;
    nx();
    chk("R6", "strobe after 4th beat", 32'(strobeN), 0);
    chk("R6", "addr next", busAddr, 32'h340);
    reqValid = 1'b0;
    nx(); readyN = 1'b0;
    nx(); readyN = 1'b1;
    nx(2);
  endtask

  // early address pipelining and ignored pulses
  task automatic t_pipe();
    present(1, 0, 0, 0, 32'h400);
    nx();
    chk("R4", "strobe A", 32'(strobeN), 0);
    present(1, 0, 0, 0, 32'h410);
    earlyAddrN = 1'b0;
    nx();
    earlyAddrN = 1'b1;
    chk("R4", "no strobe one clock after pulse", 32'(strobeN), 1);
    #1 chk("R4", "taken on second clock", 32'(reqTaken), 1);
    nx();
    chk("R4", "strobe two clocks after pulse", 32'(strobeN), 0);
    chk("R4", "addr B", busAddr, 32'h410);
    present(1, 0, 0, 0, 32'h420);
    earlyAddrN = 1'b0;
    nx();
    earlyAddrN = 1'b1;
    chk("R5", "no strobe with two outstanding", 32'(strobeN), 1);
    nx();
    chk("R10", "pulse at two outstanding ignored", 32'(strobeN), 1);
    readyN = 1'b0;
    nx();
    readyN = 1'b1;
    chk("R5", "no strobe before retire", 32'(strobeN), 1);
    #1 chk("R10", "pulse not remembered", 32'(reqTaken), 0);
    nx();
    chk("R10", "no strobe after one retire", 32'(strobeN), 1);
    reqValid = 1'b0;
    earlyAddrN = 1'b0;
    nx();
    earlyAddrN = 1'b1;
    present(1, 0, 0, 0, 32'h420);
    nx();
    chk("R10", "pulse without request ignored", 32'(strobeN), 1);
    nx();
    chk("R10", "still no strobe", 32'(strobeN), 1);
    readyN = 1'b0;
    nx();
    readyN = 1'b1;
    nx();
    chk("R3", "C strobes once idle", 32'(strobeN), 0);
    chk("R2", "addr C", busAddr, 32'h420);
    reqValid = 1'b0;
    nx(); readyN = 1'b0;
    nx(); readyN = 1'b1;
    nx(2);
  endtask

  // back-to-back locked sequences
  task automatic t_lock();
    present(1, 1, 0, 0, 32'h500);
    nx();
    chk("R7", "strobe L1", 32'(strobeN), 0);
    chk("R7", "lock with first strobe", 32'(busLockN), 0);
    present(1, 1, 1, 0, 32'h504);
    nx(); readyN = 1'b0;
    nx(); readyN = 1'b1;
    chk("R7", "lock held between cycles", 32'(busLockN), 0);
    #1 chk("R7", "closing cycle taken", 32'(reqTaken), 1);
    nx();
    chk("R7", "strobe L2", 32'(strobeN), 0);
    chk("R7", "lock during L2", 32'(busLockN), 0);
    present(1, 1, 1, 0, 32'h600);
    nx();
    readyN = 1'b0;
    chk("R8", "lock before final beat", 32'(busLockN), 0);
    #1 chk("R11", "new sequence held", 32'(reqTaken), 0);
    nx();
    readyN = 1'b1;
    chk("R8", "lock released after final beat", 32'(busLockN), 1);
    chk("R9", "no strobe in gap", 32'(strobeN), 1);
    nx();
    chk("R9", "new sequence strobe", 32'(strobeN), 0);
    chk("R9", "new sequence lock", 32'(busLockN), 0);
    reqValid = 1'b0;
    nx(); readyN = 1'b0;
    nx(); readyN = 1'b1;
    chk("R8", "lock released after L3", 32'(busLockN), 1);
    nx(2);
  endtask

  // unlocked request held while a sequence is open
  task automatic t_hold();
    present(1, 1, 0, 0, 32'h700);
    nx();
    chk("R11", "strobe L1", 32'(strobeN), 0);
    present(0, 0, 0, 0, 32'h780);
    earlyAddrN = 1'b0;
    #1 chk("R11", "unlocked not taken", 32'(reqTaken), 0);
    nx();
    earlyAddrN = 1'b1;
    readyN = 1'b0;
    nx();
    readyN = 1'b1;
    chk("R11", "no strobe after L1", 32'(strobeN), 1);
    for (int i = 0; i < 3; i++) begin
      nx();
      chk("R11", "unlocked held open seq", 32'(strobeN), 1);
      chk("R11", "lock still held", 32'(busLockN), 0);
    end
    present(1, 1, 1, 0, 32'h704);
    #1 chk("R11", "closing locked taken", 32'(reqTaken), 1);
    nx();
    chk("R11", "strobe L2", 32'(strobeN), 0);
    chk("R11", "lock during L2", 32'(busLockN), 0);
    present(0, 0, 0, 0, 32'h780);
    nx(); readyN = 1'b0;
    nx(); readyN = 1'b1;
    chk("R8", "lock released", 32'(busLockN), 1);
    chk("R9", "gap after close", 32'(strobeN), 1);
    nx();
    chk("R11", "unlocked strobe after close", 32'(strobeN), 0);
    chk("R11", "unlocked without lock", 32'(busLockN), 1);
    chk("R2", "unlocked io type", 32'(busIsMem), 0);
    reqValid = 1'b0;
    nx(); readyN = 1'b0;
    nx(); readyN = 1'b1;
    nx(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_burst();
    t_pipe();
    t_lock();
    t_hold();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule